// File: doc/BRIEF.md
# I2C Bit-Rate Prescaler

This block derives the timing of an I2C master's clock line from the system clock. Two divider stages are cascaded. The first divides the system clock by a power of two. The second divides that result by a linear factor. Together they produce a sample tick that runs at ten times the SCL rate. A phase state machine counts these ticks into SCL periods of ten ticks each: five low and five high. It emits a one-clock strobe at four fixed points of each period. The bit engine uses the strobes to place START, STOP and data edges.

The rate is set by an 8-bit setting word. Bits 6:3 hold the linear factor M (0..15), bits 2:0 hold the exponent N (0..7), and bit 7 is ignored. The tick interval is 2^(N+1)·(M+1) system clocks, so SCL = f_clk / (10·(M+1)·2^(N+1)). Setting the parameter `POW_EXTRA` to 0 selects the variant with 2^N instead. A written setting is held as pending. While the prescaler runs, the pending setting takes effect only when the current SCL period ends. While the prescaler is stopped, it takes effect on the next clock. A soft reset restores the default setting 0x44 (M = 8, N = 4).

The phase state machine has three states:
- `ST_IDLE`: stopped, SCL high.
- `ST_LOW`: SCL low half.
- `ST_HIGH`: SCL high half.

Its transitions, each taken on a sample tick, are:
- `start`: `ST_IDLE`→`ST_LOW`.
- `to_high`: `ST_LOW`→`ST_HIGH` after the fifth low tick.
- `wrap`: `ST_HIGH`→`ST_LOW` after the fifth high tick. This is the period boundary.
- `halt`: any state→`ST_IDLE`, taken when `run` is low or on soft reset, without waiting for a tick.

Top module: `i2c_rate_prescaler`

## Requirements
- R1: After `rst_n` is asserted, `rate_q` reads 0x44, `scl_o` is 1, and `tick_o`, `fall_o`, `data_o`, `rise_o` and `samp_o` are all 0.
- R2: A written setting is decoded with M from bits 6:3 and N from bits 2:0. Bit 7 is discarded, so `rate_q` bit 7 always reads 0.
- R3: While `run` is high, `tick_o` pulses for one clock every 2^(N+1)·(M+1) clocks (2^N·(M+1) when `POW_EXTRA` is 0). M and N come from the setting in force.
- R4: Starting from idle, the first tick drives `scl_o` low. From then on `scl_o` stays low for five ticks and high for five ticks, so one SCL period is ten ticks.
- R5: The strobes sit at fixed tick positions of the period, counting the first low tick as position 0. `fall_o` is at position 0, `data_o` at position 2, `rise_o` at position 5 and `samp_o` at position 7. Each strobe coincides with `tick_o`.
- R6: A setting written while running leaves `rate_q` and the tick spacing unchanged until the tick that ends the high half. The new setting is in force from the next clock.
- R7: While `run` is low, `scl_o` is 1, no tick or strobe occurs, and a written setting appears on `rate_q` one clock after the write clock.
- R8: A one-clock `soft_rst` restores setting 0x44, discards the pending setting, and returns the phase machine to idle with `scl_o` high.
- R9: At most one of the four phase strobes is high in any clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| soft_rst | input | 1 | Synchronous reset to default setting and idle |
| run | input | 1 | Run enable for the dividers and the phase machine |
| cfg_wr | input | 1 | Write strobe for the rate setting |
| cfg_data | input | 8 | Rate setting (M in 6:3, N in 2:0) |
| rate_q | output | 8 | Setting currently in force |
| tick_o | output | 1 | Sample tick, ten per SCL period |
| scl_o | output | 1 | SCL level timing (1 = released/high) |
| fall_o | output | 1 | SCL falling-edge strobe |
| data_o | output | 1 | Data-change strobe, mid low half |
| rise_o | output | 1 | SCL rising-edge strobe |
| samp_o | output | 1 | Data-sample strobe, mid high half |

## Verification
Several properties are checked on every cycle by assertions:
- The phase strobes stay mutually exclusive and each coincides with a tick.
- `rise_o` and `fall_o` coincide with actual level changes of `scl_o`.
- Both divider counters stay inside their limits.
- The setting in force changes only on a period boundary, while stopped, or on soft reset.
- Stopping silences the outputs on the next clock.

Other behaviour can be shown only by the bench's scenarios, against a reference model that uses a single flat counter:
- the exact tick spacing for each setting, including the minimum setting (0x00) and the maximum (0x7F);
- the position of each strobe within the ten-tick period;
- the deferral of a mid-period write to the following period;
- restart after a stop and after a soft reset.

// File: rtl/i2c_presc_pkg.sv
package i2c_presc_pkg;
    localparam int M_W = 4;
    localparam int N_W = 3;
    localparam logic [7:0] RATE_DEFAULT = 8'h44;

    typedef struct packed {
        logic           rsv;
        logic [M_W-1:0] m;
        logic [N_W-1:0] n;
    } rate_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOW  = 2'd1,
        ST_HIGH = 2'd2
    } phase_e;
endpackage

// File: rtl/rate_store.sv
module rate_store
    import i2c_presc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       soft_rst,
    input  logic       wr,
    input  logic [7:0] wdata,
    input  logic       apply,
    output rate_t      act_o
);
    localparam logic RSV_KEEP = 1'b0;

    rate_t pend_q;
    rate_t act_q;
    rate_t wr_val;

    always_comb begin
        wr_val.rsv = wdata[7] & RSV_KEEP;
        wr_val.m   = wdata[6:3];
        wr_val.n   = wdata[2:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= rate_t'(RATE_DEFAULT);
            act_q  <= rate_t'(RATE_DEFAULT);
        end else if (soft_rst) begin
            pend_q <= rate_t'(RATE_DEFAULT);
            act_q  <= rate_t'(RATE_DEFAULT);
        end else begin
            if (wr)
                pend_q <= wr_val;
            if (apply)
                act_q <= pend_q;
        end
    end

    assign act_o = act_q;

    // R6: setting in force moves only on apply or soft reset
    a_r6_hold_until_apply: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(act_q) |-> $past(apply || soft_rst));
    // R2: discarded bit never reaches the setting in force
    a_r2_rsv_zero: assert property (@(posedge clk) disable iff (!rst_n)
        act_q.rsv == 1'b0);
endmodule

// File: rtl/pow2_stage.sv
module pow2_stage #(
    parameter int N_W   = 3,
    parameter int EXTRA = 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clr,
    input  logic [N_W-1:0] n,
    output logic           pulse
);
    localparam int CW = (1 << N_W) - 1 + EXTRA;

    logic [CW-1:0] cnt_q;
    logic [CW:0]   span;
    logic [CW:0]   lim;

    always_comb begin
        span  = {{CW{1'b0}}, 1'b1} << (int'(n) + EXTRA);
        lim   = span - 1'b1;
        pulse = !clr && (cnt_q == lim[CW-1:0]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (clr || pulse)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end

    // R3: exponential stage never runs past its limit
    a_r3_pow_bound: assert property (@(posedge clk) disable iff (!rst_n)
        {1'b0, cnt_q} <= lim);
endmodule

// File: rtl/lin_stage.sv
module lin_stage #(
    parameter int M_W = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clr,
    input  logic           step,
    input  logic [M_W-1:0] m,
    output logic           tick
);
    logic [M_W-1:0] cnt_q;

    assign tick = step && (cnt_q == m);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (clr || tick)
            cnt_q <= '0;
        else if (step)
            cnt_q <= cnt_q + 1'b1;
    end

    // R3: linear stage never runs past M
    a_r3_lin_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= m);
endmodule

// File: rtl/phase_fsm.sv
module phase_fsm
    import i2c_presc_pkg::*;
#(
    parameter int HALF       = 5,
    parameter int DATA_POS   = 2,
    parameter int SAMPLE_POS = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic tick,
    output logic boundary,
    output logic tick_o,
    output logic scl_o,
    output logic fall_o,
    output logic data_o,
    output logic rise_o,
    output logic samp_o
);
    localparam int IW = (HALF > 1) ? $clog2(HALF) : 1;
    localparam logic [IW-1:0] LAST = IW'(HALF - 1);
    localparam logic [IW-1:0] DPOS = IW'(DATA_POS);
    localparam logic [IW-1:0] SPOS = IW'(SAMPLE_POS);

    phase_e        st_q, st_d;
    logic [IW-1:0] idx_q, idx_d;

    assign boundary = tick && (st_q == ST_HIGH) && (idx_q == LAST);

    always_comb begin
        st_d  = st_q;
        idx_d = idx_q;
        if (clr) begin
            st_d  = ST_IDLE;
            idx_d = '0;
        end else if (tick) begin
            unique case (st_q)
                ST_IDLE: begin
                    st_d  = ST_LOW;
                    idx_d = '0;
                end
                ST_LOW: begin
                    if (idx_q == LAST) begin
                        st_d  = ST_HIGH;
                        idx_d = '0;
                    end else begin
                        idx_d = idx_q + 1'b1;
                    end
                end
                ST_HIGH: begin
                    if (idx_q == LAST) begin
                        st_d  = ST_LOW;
                        idx_d = '0;
                    end else begin
                        idx_d = idx_q + 1'b1;
                    end
                end
                default: begin
                    st_d  = ST_IDLE;
                    idx_d = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            idx_q <= '0;
        end else begin
            st_q  <= st_d;
            idx_q <= idx_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tick_o <= 1'b0;
            scl_o  <= 1'b1;
            fall_o <= 1'b0;
            data_o <= 1'b0;
            rise_o <= 1'b0;
            samp_o <= 1'b0;
        end else begin
            tick_o <= tick && !clr;
            scl_o  <= (st_d != ST_LOW);
            fall_o <= tick && !clr && (st_d == ST_LOW)  && (idx_d == '0) && (st_q != ST_LOW);
            data_o <= tick && !clr && (st_d == ST_LOW)  && (idx_d == DPOS);
            rise_o <= tick && !clr && (st_d == ST_HIGH) && (idx_d == '0);
            samp_o <= tick && !clr && (st_d == ST_HIGH) && (idx_d == SPOS);
        end
    end

    // R9: phase strobes are mutually exclusive
    a_r9_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({fall_o, data_o, rise_o, samp_o}));
    // R5: every strobe lands on a sample tick
    a_r5_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (fall_o || data_o || rise_o || samp_o) |-> tick_o);
    // R4: rise strobe marks a real low-to-high change
    a_r4_rise_edge: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rise_o) |-> (scl_o && !$past(scl_o)));
    // R4: fall strobe marks a real high-to-low change
    a_r4_fall_edge: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fall_o) |-> (!scl_o && $past(scl_o)));
endmodule

// File: rtl/i2c_rate_prescaler.sv
module i2c_rate_prescaler
    import i2c_presc_pkg::*;
#(
    parameter int POW_EXTRA  = 1,
    parameter int HALF       = 5,
    parameter int DATA_POS   = 2,
    parameter int SAMPLE_POS = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       soft_rst,
    input  logic       run,
    input  logic       cfg_wr,
    input  logic [7:0] cfg_data,
    output logic [7:0] rate_q,
    output logic       tick_o,
    output logic       scl_o,
    output logic       fall_o,
    output logic       data_o,
    output logic       rise_o,
    output logic       samp_o
);
    rate_t act;
    logic  clr;
    logic  pre_pulse;
    logic  tick;
    logic  boundary;
    logic  apply;

    assign clr    = soft_rst || !run;
    assign apply  = !run || boundary;
    assign rate_q = act;

    rate_store u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_rst (soft_rst),
        .wr       (cfg_wr),
        .wdata    (cfg_data),
        .apply    (apply),
        .act_o    (act)
    );

    pow2_stage #(.N_W(N_W), .EXTRA(POW_EXTRA)) u_pow2 (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr),
        .n     (act.n),
        .pulse (pre_pulse)
    );

    lin_stage #(.M_W(M_W)) u_lin (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr),
        .step  (pre_pulse),
        .m     (act.m),
        .tick  (tick)
    );

    phase_fsm #(.HALF(HALF), .DATA_POS(DATA_POS), .SAMPLE_POS(SAMPLE_POS)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr),
        .tick     (tick),
        .boundary (boundary),
        .tick_o   (tick_o),
        .scl_o    (scl_o),
        .fall_o   (fall_o),
        .data_o   (data_o),
        .rise_o   (rise_o),
        .samp_o   (samp_o)
    );

    // R7: stopping silences the line one clock later
    a_r7_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (scl_o && !tick_o));
    // R8: soft reset returns to the default setting
    a_r8_soft_default: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (rate_q == RATE_DEFAULT && scl_o));
endmodule

// File: tb/sim_i2c_rate_prescaler.sv
module sim_i2c_rate_prescaler;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       soft_rst = 1'b0;
    logic       run = 1'b0;
    logic       cfg_wr = 1'b0;
    logic [7:0] cfg_data = 8'h00;
    logic [7:0] rate_q;
    logic       tick_o, scl_o, fall_o, data_o, rise_o, samp_o;

    int n_cmp = 0;
    int n_bad = 0;
    int cycles = 0;
    bit cmp_en = 1'b0;

    // reference model state
    int m_pend = 8'h44, m_act = 8'h44, m_cnt = 0, m_pos = -1;
    int e_tick = 0, e_scl = 1, e_fall = 0, e_data = 0, e_rise = 0, e_samp = 0;

    always #4 clk = ~clk;

    i2c_rate_prescaler u0 (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .run(run),
        .cfg_wr(cfg_wr), .cfg_data(cfg_data), .rate_q(rate_q),
        .tick_o(tick_o), .scl_o(scl_o), .fall_o(fall_o), .data_o(data_o),
        .rise_o(rise_o), .samp_o(samp_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at cycle %0d", req, act, exp, cycles);
        end
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // behavioural model: one flat counter per tick, positions 0..9
    always @(posedge clk) begin
        int lim, newpos;
        bit t;
        cycles++;
        lim = (1 << ((m_act & 7) + 1)) * (((m_act >> 3) & 15) + 1);
        if (!rst_n || soft_rst) begin
            m_pend = 8'h44; m_act = 8'h44; m_cnt = 0; m_pos = -1;
            e_tick = 0; e_scl = 1; e_fall = 0; e_data = 0; e_rise = 0; e_samp = 0;
        end else if (!run) begin
            m_act = m_pend;
            if (cfg_wr) m_pend = cfg_data & 8'h7F;
            m_cnt = 0; m_pos = -1;
            e_tick = 0; e_scl = 1; e_fall = 0; e_data = 0; e_rise = 0; e_samp = 0;
        end else begin
            t = (m_cnt == lim - 1);
            m_cnt = t ? 0 : m_cnt + 1;
            e_tick = t;
            e_fall = 0; e_data = 0; e_rise = 0; e_samp = 0;
            if (t) begin
                newpos = (m_pos < 0) ? 0 : (m_pos + 1) % 10;
                if (m_pos == 9) m_act = m_pend;
                m_pos = newpos;
                e_fall = (newpos == 0);
                e_data = (newpos == 2);
                e_rise = (newpos == 5);
                e_samp = (newpos == 7);
            end
            e_scl = (m_pos < 0 || m_pos >= 5) ? 1 : 0;
            if (cfg_wr) m_pend = cfg_data & 8'h7F;
        end
    end

    always @(negedge clk) begin
        if (cmp_en) begin
            chk("R3 tick", tick_o, e_tick);
            chk("R4 scl", scl_o, e_scl);
            chk("R5 fall", fall_o, e_fall);
            chk("R5 data", data_o, e_data);
            chk("R5 rise", rise_o, e_rise);
            chk("R5 samp", samp_o, e_samp);
            chk("R6 rate", rate_q, m_act);
        end
        if (cycles > 190000) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual %0d expected <190000 cycles", cycles);
            finish_run();
        end
    end

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] v);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_data = v;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    initial begin
        cyc(3);
        // R1 reset state
        chk("R1 rate", rate_q, 8'h44);
        chk("R1 scl", scl_o, 1);
        chk("R1 strobes", {tick_o, fall_o, data_o, rise_o, samp_o}, 0);
        rst_n = 1'b1;
        cyc(1);
        cmp_en = 1'b1;
        run = 1'b1;
        cyc(3500);
        // R6 write mid-period with bit 7 set; R2 drops bit 7
        wr(8'h80);
        cyc(2);
        chk("R6 held", rate_q, 8'h44);
        cyc(3000);
        chk("R2 decode", rate_q, 8'h00);
        cyc(100);
        wr(8'h19);
        cyc(400);
        chk("R2 fields", rate_q, 8'h19);
        // R8 soft reset mid-run
        @(negedge clk); soft_rst = 1'b1;
        @(negedge clk); soft_rst = 1'b0;
        chk("R8 rate", rate_q, 8'h44);
        chk("R8 scl", scl_o, 1);
        cyc(50);
        // R7 stopped: write applies next clock
        run = 1'b0;
        cyc(2);
        wr(8'h7F);
        cyc(1);
        chk("R7 rate", rate_q, 8'h7F);
        chk("R7 scl", scl_o, 1);
        chk("R7 tick", tick_o, 0);
        run = 1'b1;
        cyc(42000);
        wr(8'h01);
        cyc(41000);
        chk("R6 applied", rate_q, 8'h01);
        run = 1'b0; cyc(5);
        run = 1'b1; cyc(200);
        finish_run();
    end
endmodule